// File: doc/BRIEF.md
# Two-Phase Migratable Process Core

This block is a small 16-bit processor that runs one compiled simulation process once per simulation cycle. A host loads a program image, data words and register contents through an access port, pulses `start`, and waits for `done`. The core then fetches and executes instructions until it reaches a halt instruction. It goes idle again with its program counter back at zero. Every piece of state (program memory, data memory, register file) can be written or read back through the same port while the core is idle. This lets a process be moved into or out of the core between simulation cycles.

Process inputs and outputs live in aliased registers. Registers r6 and r7 hold the two input mailbox words, which the host writes before a cycle. Register r5 is the output mailbox, which the core writes and the `out_mbox` pin shows at all times. Each instruction takes a fetch cycle and an execute cycle with no overlap, so no hazard logic exists.

The access port is valid/ready. A request is accepted on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is high only while the core is idle, so a request made during a run waits and has no effect. A read response appears on `rd_valid`/`rd_data` one cycle after acceptance. The response has no back-pressure, so the host must take it in that cycle.

Top module: `mproc_core`

## Requirements
- R1: After reset, `busy` and `done` are 0, `acc_ready` is 1, and `out_mbox` reads 0.
- R2: Instruction layout is op[15:12], rd[11:9], rs[8:6], rt[5:3]. Ops 0..5 compute rd = rs op rt as ADD, SUB, AND, OR, XOR and signed less-than (result 1 or 0), modulo 2^16.
- R3: A run of N executed instructions, including the final halt, raises `done` exactly 2N clock cycles after the edge that accepts `start`.
- R4: Op 6 (LDI) loads the 8-bit immediate in bits [7:0] into rd with zero extension. Op 7 (LD) sets rd = data[rs]. Op 8 (ST) writes register rd into data[rs]. Data addresses use the low address bits of the register.
- R5: Op 9 branches to immediate [7:0] when rd equals zero. Op A branches when rd is not zero. Op B jumps unconditionally. Otherwise the program counter advances by one.
- R6: Reads of r6 and r7 return the input mailbox words written by the host. Writes to r6 and r7 by the program are discarded.
- R7: A program write to r5 appears on `out_mbox`. While idle, `out_mbox` changes only through a host write to register 5.
- R8: Op F (HALT) makes `done` high for exactly one cycle with `busy` low. The program counter returns to 0, so the next run starts at address 0.
- R9: Access spaces are 0 = program, 1 = data, 2 = registers (address [2:0]), and 3 = none (reads 0). Requests are accepted only while idle, and a request made while busy changes nothing. A read returns its word with `rd_valid` one cycle after acceptance.
- R10: Ops C, D and E change no register, memory or mailbox and take two cycles like any other instruction.
- R11: `start` is ignored while the core is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one simulation cycle (taken when idle) |
| busy | output | 1 | Core is running a cycle |
| done | output | 1 | One-cycle pulse when the cycle ends |
| acc_valid | input | 1 | Host access request valid |
| acc_ready | output | 1 | Host access accepted (core idle) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | Target: 0 program, 1 data, 2 registers |
| acc_addr | input | MEM_AW | Word address within the space |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Read response word |
| out_mbox | output | 16 | Output mailbox (register r5) |

## Verification
The bench builds the core with the default MEM_AW of 8, giving 256-word program and data memories. That size lets the data-memory sweep spread store and load addresses across the whole space. The small operand set makes a full cross of every ALU operation with every pair of a dozen corner values (zero, one, sign boundaries, alternating bits) cheap. Multiply-by-loop programs with trip counts 0 through 7 exercise both branch polarities and the exact two-cycle-per-instruction run length.

// File: rtl/mproc_pkg.sv
package mproc_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned NREGS   = 1 << REG_AW;
  localparam int unsigned REG_OUT = 5;
  localparam int unsigned REG_IN0 = 6;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_AND  = 4'h2;
  localparam logic [3:0] OP_OR   = 4'h3;
  localparam logic [3:0] OP_XOR  = 4'h4;
  localparam logic [3:0] OP_SLT  = 4'h5;
  localparam logic [3:0] OP_LDI  = 4'h6;
  localparam logic [3:0] OP_LD   = 4'h7;
  localparam logic [3:0] OP_ST   = 4'h8;
  localparam logic [3:0] OP_BEQ  = 4'h9;
  localparam logic [3:0] OP_BNE  = 4'hA;
  localparam logic [3:0] OP_JMP  = 4'hB;
  localparam logic [3:0] OP_HALT = 4'hF;

  localparam logic [1:0] SP_PROG = 2'd0;
  localparam logic [1:0] SP_DATA = 2'd1;
  localparam logic [1:0] SP_REGS = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} state_e;
endpackage

// File: rtl/mproc_alu.sv
module mproc_alu
  import mproc_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLT:  y = ($signed(a) < $signed(b)) ? WORD_W'(1) : '0;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mproc_ram.sv
module mproc_ram #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/mproc_regfile.sv
module mproc_regfile
  import mproc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_we,
  input  logic [REG_AW-1:0] core_wa,
  input  logic [WORD_W-1:0] core_wd,
  input  logic              host_we,
  input  logic [REG_AW-1:0] host_wa,
  input  logic [WORD_W-1:0] host_wd,
  input  logic [REG_AW-1:0] ra_a,
  output logic [WORD_W-1:0] rd_a,
  input  logic [REG_AW-1:0] ra_b,
  output logic [WORD_W-1:0] rd_b,
  input  logic [REG_AW-1:0] ra_h,
  output logic [WORD_W-1:0] rd_h,
  output logic [WORD_W-1:0] out_word
);
  logic [WORD_W-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i >= REG_IN0) begin : g_in
      // input alias: only the host may load it
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= '0;
        else if (host_we && host_wa == REG_AW'(i)) regs[i] <= host_wd;
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= '0;
        else if (host_we && host_wa == REG_AW'(i)) regs[i] <= host_wd;
        else if (core_we && core_wa == REG_AW'(i)) regs[i] <= core_wd;
      end
    end
  end

  assign rd_a     = regs[ra_a];
  assign rd_b     = regs[ra_b];
  assign rd_h     = regs[ra_h];
  assign out_word = regs[REG_OUT];
endmodule

// File: rtl/mproc_core.sv
module mproc_core
  import mproc_pkg::*;
#(
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [1:0]        acc_space,
  input  logic [MEM_AW-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] out_mbox
);
  state_e            state;
  logic [MEM_AW-1:0] pc, pc_nxt;
  logic [WORD_W-1:0] ir;

  logic [3:0]        opc;
  logic [REG_AW-1:0] f_rd, f_rs, f_rt;
  logic [7:0]        imm;
  assign opc  = ir[15:12];
  assign f_rd = ir[11:9];
  assign f_rs = ir[8:6];
  assign f_rt = ir[5:3];
  assign imm  = ir[7:0];

  logic exec;
  assign exec      = (state == ST_EXEC);
  assign busy      = (state != ST_IDLE);
  assign acc_ready = !busy;

  logic acc_fire, host_wr;
  assign acc_fire = acc_valid && acc_ready;
  assign host_wr  = acc_fire && acc_write;

  // register file
  logic [WORD_W-1:0] r_a, r_b, r_h, alu_y, dm_core, dm_host, pm_core, pm_host;
  logic              core_we;
  logic [WORD_W-1:0] core_wd;
  logic              uses_rd_as_src;

  assign uses_rd_as_src = (opc == OP_ST) || (opc == OP_BEQ) || (opc == OP_BNE);
  assign core_we = exec && ((opc <= OP_SLT) || (opc == OP_LDI) || (opc == OP_LD));

  always_comb begin
    if (opc == OP_LDI)     core_wd = WORD_W'(imm);
    else if (opc == OP_LD) core_wd = dm_core;
    else                   core_wd = alu_y;
  end

  mproc_regfile u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_we  (core_we),
    .core_wa  (f_rd),
    .core_wd  (core_wd),
    .host_we  (host_wr && acc_space == SP_REGS),
    .host_wa  (acc_addr[REG_AW-1:0]),
    .host_wd  (acc_wdata),
    .ra_a     (f_rs),
    .rd_a     (r_a),
    .ra_b     (uses_rd_as_src ? f_rd : f_rt),
    .rd_b     (r_b),
    .ra_h     (acc_addr[REG_AW-1:0]),
    .rd_h     (r_h),
    .out_word (out_mbox)
  );

  mproc_alu u_alu (
    .op (opc),
    .a  (r_a),
    .b  (r_b),
    .y  (alu_y)
  );

  // program memory: host writes, core fetches
  mproc_ram #(.W(WORD_W), .AW(MEM_AW)) u_pmem (
    .clk     (clk),
    .we      (host_wr && acc_space == SP_PROG),
    .waddr   (acc_addr),
    .wdata   (acc_wdata),
    .raddr_a (pc),
    .rdata_a (pm_core),
    .raddr_b (acc_addr),
    .rdata_b (pm_host)
  );

  // data memory: store and host write never coincide (host only when idle)
  logic st_now;
  assign st_now = exec && (opc == OP_ST);

  mproc_ram #(.W(WORD_W), .AW(MEM_AW)) u_dmem (
    .clk     (clk),
    .we      (st_now || (host_wr && acc_space == SP_DATA)),
    .waddr   (st_now ? r_a[MEM_AW-1:0] : acc_addr),
    .wdata   (st_now ? r_b : acc_wdata),
    .raddr_a (r_a[MEM_AW-1:0]),
    .rdata_a (dm_core),
    .raddr_b (acc_addr),
    .rdata_b (dm_host)
  );

  // next program counter
  always_comb begin
    pc_nxt = pc + MEM_AW'(1);
    case (opc)
      OP_HALT: pc_nxt = '0;
      OP_JMP:  pc_nxt = MEM_AW'(imm);
      OP_BEQ:  if (r_b == '0) pc_nxt = MEM_AW'(imm);
      OP_BNE:  if (r_b != '0) pc_nxt = MEM_AW'(imm);
      default: ;
    endcase
  end

  // two-phase sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
      ir    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:  if (start) state <= ST_FETCH;
        ST_FETCH: begin
          ir    <= pm_core;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          pc <= pc_nxt;
          if (opc == OP_HALT) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // host read response, one cycle after acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_fire && !acc_write;
      if (acc_fire && !acc_write) begin
        case (acc_space)
          SP_PROG: rd_data <= pm_host;
          SP_DATA: rd_data <= dm_host;
          SP_REGS: rd_data <= r_h;
          default: rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mproc_core_chk.sv
module mproc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        acc_valid,
  input logic        acc_ready,
  input logic        acc_write,
  input logic        rd_valid,
  input logic [15:0] out_mbox
);
  // run-length parity: counts edges spent busy
  logic par;
  always_ff @(posedge clk) begin
    if (!rst_n) par <= 1'b0;
    else        par <= busy ? ~par : 1'b0;
  end

  assert_even_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !par);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_ready);

  assert_read_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && acc_ready && !acc_write));

  assert_out_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(acc_valid && acc_ready && acc_write))
      |-> $stable(out_mbox));

  assert_start_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(busy)));
endmodule

bind mproc_core mproc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_write (acc_write),
  .rd_valid  (rd_valid),
  .out_mbox  (out_mbox)
);

// File: tb/mproc_core_test.sv
module mproc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_space = 2'd0;
  logic [7:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data, out_mbox;

  int checks = 0;
  int fails  = 0;
  logic [15:0] prog [16];

  always #10 clk = ~clk;

  mproc_core #(.MEM_AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .out_mbox(out_mbox)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_r(input logic [3:0] op, input int rd,
                                        input int rs, input int rt);
    return {op, 3'(rd), 3'(rs), 3'(rt), 3'b000};
  endfunction

  function automatic logic [15:0] enc_i(input logic [3:0] op, input int rd,
                                        input logic [7:0] imm);
    return {op, 3'(rd), 1'b0, imm};
  endfunction

  task automatic host_write(input logic [1:0] sp, input logic [7:0] a,
                            input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_space = sp; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sp, input logic [7:0] a,
                           output logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_space = sp; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    d = rd_data;
    check(rd_valid == 1'b1, "R9 read response valid", 32'(rd_valid), 32'd1);
  endtask

  task automatic load_prog(input int n);
    for (int i = 0; i < n; i++) host_write(2'd0, 8'(i), prog[i]);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(busy == 1'b0, "R8 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    check(done == 1'b0, "R8 done lasts one cycle", 32'(done), 32'd0);
  endtask

  function automatic logic [15:0] alu_ref(input int op, input logic [15:0] a,
                                          input logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] vals [12];
    logic [15:0] rdw;
    int cyc;
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF,
             16'h1234, 16'hFEDC, 16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", 32'(busy), 0);
    check(done == 1'b0, "R1 done", 32'(done), 0);
    check(acc_ready == 1'b1, "R1 ready", 32'(acc_ready), 1);
    check(out_mbox == 16'h0, "R1 out_mbox", 32'(out_mbox), 0);

    // R4 LDI zero extension, R3 length, R8 restart at address 0
    prog[0] = enc_i(4'h6, 5, 8'hAB);
    prog[1] = 16'hF000;
    load_prog(2);
    run(cyc);
    check(out_mbox == 16'h00AB, "R4 LDI zero-extend", 32'(out_mbox), 32'h00AB);
    check(cyc == 4, "R3 two instr cycles", cyc, 4);
    host_write(2'd2, 8'd5, 16'h0000);
    run(cyc);
    check(out_mbox == 16'h00AB, "R8 rerun from pc 0", 32'(out_mbox), 32'h00AB);
    host_read(2'd0, 8'd1, rdw);
    check(rdw == 16'hF000, "R9 program readback", 32'(rdw), 32'hF000);
    host_read(2'd3, 8'd1, rdw);
    check(rdw == 16'h0000, "R9 space 3 reads 0", 32'(rdw), 0);

    // R2 / R6 / R7 ALU sweep: r5 = r6 op r7
    for (int op = 0; op < 6; op++) begin
      prog[0] = enc_r(4'(op), 5, 6, 7);
      prog[1] = 16'hF000;
      load_prog(2);
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          host_write(2'd2, 8'd6, vals[i]);
          host_write(2'd2, 8'd7, vals[j]);
          run(cyc);
          check(out_mbox == alu_ref(op, vals[i], vals[j]), "R2 R7 alu result",
                32'(out_mbox), 32'(alu_ref(op, vals[i], vals[j])));
          check(cyc == 4, "R3 alu run length", cyc, 4);
        end
      end
    end

    // R6 program write to input alias discarded
    prog[0] = enc_i(4'h6, 0, 8'h00);
    prog[1] = enc_i(4'h6, 6, 8'h55);
    prog[2] = enc_r(4'h0, 5, 6, 0);
    prog[3] = 16'hF000;
    load_prog(4);
    host_write(2'd2, 8'd6, 16'h1234);
    run(cyc);
    check(out_mbox == 16'h1234, "R6 input alias kept", 32'(out_mbox), 32'h1234);
    host_read(2'd2, 8'd6, rdw);
    check(rdw == 16'h1234, "R6 r6 readback", 32'(rdw), 32'h1234);
    check(cyc == 8, "R3 four instr", cyc, 8);

    // R4 store/load sweep over data memory
    prog[0] = enc_r(4'h8, 6, 7, 0);
    prog[1] = enc_r(4'h7, 3, 7, 0);
    prog[2] = enc_r(4'h0, 5, 3, 3);
    prog[3] = 16'hF000;
    load_prog(4);
    for (int a = 0; a < 256; a += 17) begin
      logic [15:0] v;
      v = 16'(a * 16'h0101 + 16'h3C);
      host_write(2'd2, 8'd6, v);
      host_write(2'd2, 8'd7, 16'hAB00 | 16'(a));
      run(cyc);
      check(out_mbox == 16'(2 * v), "R4 LD after ST", 32'(out_mbox), 32'(16'(2 * v)));
      host_read(2'd1, 8'(a), rdw);
      check(rdw == v, "R4 ST data readback", 32'(rdw), 32'(v));
    end

    // R5 BEQ/JMP loop: r5 = r6 * r7
    prog[0] = enc_i(4'h6, 0, 8'h00);
    prog[1] = enc_i(4'h6, 2, 8'h01);
    prog[2] = enc_r(4'h0, 4, 7, 0);
    prog[3] = enc_r(4'h0, 1, 0, 0);
    prog[4] = enc_i(4'h9, 4, 8'd8);
    prog[5] = enc_r(4'h0, 1, 1, 6);
    prog[6] = enc_r(4'h1, 4, 4, 2);
    prog[7] = enc_i(4'hB, 0, 8'd4);
    prog[8] = enc_r(4'h0, 5, 1, 0);
    prog[9] = 16'hF000;
    load_prog(10);
    for (int k = 0; k < 8; k++) begin
      host_write(2'd2, 8'd6, 16'h1003);
      host_write(2'd2, 8'd7, 16'(k));
      run(cyc);
      check(out_mbox == 16'(16'h1003 * k), "R5 beq loop result",
            32'(out_mbox), 32'(16'(16'h1003 * k)));
      check(cyc == 2 * (4 * k + 7), "R3 R5 beq loop length", cyc, 2 * (4 * k + 7));
    end

    // R5 BNE loop
    prog[4] = enc_r(4'h0, 1, 1, 6);
    prog[5] = enc_r(4'h1, 4, 4, 2);
    prog[6] = enc_i(4'hA, 4, 8'd4);
    prog[7] = enc_r(4'h0, 5, 1, 0);
    prog[8] = 16'hF000;
    load_prog(9);
    for (int k = 1; k < 8; k++) begin
      host_write(2'd2, 8'd6, 16'h0777);
      host_write(2'd2, 8'd7, 16'(k));
      run(cyc);
      check(out_mbox == 16'(16'h0777 * k), "R5 bne loop result",
            32'(out_mbox), 32'(16'(16'h0777 * k)));
      check(cyc == 2 * (3 * k + 6), "R3 R5 bne loop length", cyc, 2 * (3 * k + 6));
    end

    // R10 unused opcodes are no-ops
    prog[0] = enc_i(4'h6, 5, 8'h03);
    prog[1] = 16'hCFFF;
    prog[2] = 16'hDFFF;
    prog[3] = 16'hEFFF;
    prog[4] = 16'hF000;
    load_prog(5);
    run(cyc);
    check(out_mbox == 16'h0003, "R10 no-op leaves r5", 32'(out_mbox), 3);
    check(cyc == 10, "R10 no-op length", cyc, 10);

    // R9 / R11 accesses and start while busy
    prog[0] = enc_i(4'h6, 0, 8'h00);
    prog[1] = enc_i(4'h6, 2, 8'h01);
    prog[2] = enc_r(4'h0, 4, 7, 0);
    prog[3] = enc_r(4'h0, 1, 0, 0);
    prog[4] = enc_i(4'h9, 4, 8'd8);
    prog[5] = enc_r(4'h0, 1, 1, 6);
    prog[6] = enc_r(4'h1, 4, 4, 2);
    prog[7] = enc_i(4'hB, 0, 8'd4);
    prog[8] = enc_r(4'h0, 5, 1, 0);
    prog[9] = 16'hF000;
    load_prog(10);
    host_write(2'd1, 8'h40, 16'hBEEF);
    host_write(2'd2, 8'd6, 16'd5);
    host_write(2'd2, 8'd7, 16'd7);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    acc_valid = 1'b1; acc_write = 1'b1; acc_space = 2'd1; acc_addr = 8'h40;
    acc_wdata = 16'h0000;
    for (int i = 0; i < 3; i++) begin
      check(acc_ready == 1'b0, "R9 not ready while busy", 32'(acc_ready), 0);
      @(negedge clk);
      cyc++;
    end
    acc_valid = 1'b0; acc_write = 1'b0;
    start = 1'b1;
    @(negedge clk);
    cyc++;
    start = 1'b0;
    acc_valid = 1'b1; acc_space = 2'd2; acc_addr = 8'd5;
    @(negedge clk);
    cyc++;
    acc_valid = 1'b0;
    check(rd_valid == 1'b0, "R9 no read while busy", 32'(rd_valid), 0);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 70, "R3 R11 long run length", cyc, 70);
    check(out_mbox == 16'd35, "R11 result unaffected", 32'(out_mbox), 35);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R11 no second run", 32'(busy), 0);
    host_read(2'd1, 8'h40, rdw);
    check(rdw == 16'hBEEF, "R9 busy write ignored", 32'(rdw), 32'hBEEF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule